// File: doc/BRIEF.md
# Multi-Source Interrupt Vector Controller

This block gathers interrupt events from four source groups of a small processor system: a clock timer with three rates, a stopwatch with two rates, a serial port that signals the end of each 8-bit transfer, and three groups of key input pins. Each event sets a factor flag. Each flag is gated by its own mask bit and by one global interrupt-enable bit. When any enabled flag is pending, the block raises a request to the CPU.

The request and acknowledge pins form a valid/ready pair. `int_req_o` is the valid signal. It stays high, and the vector it implies may grow while it waits, until the CPU returns `int_ack_i`. No request is taken and no state changes while the acknowledge is missing. On the accepting edge, the block does three things:

- It captures a 4-bit vector, which is a bitmap of the source groups pending at that moment, so simultaneous groups give combined vectors 1 to 15.
- It clears the global enable.
- It holds the captured jump address stable through a fixed entry window, during which the CPU saves its program counter.

The block also gates the CPU clock while the CPU is halted. An enabled request, or a watchdog reset while the watchdog is enabled, restarts the clock. Software sees the block through a 4-bit register port. It can write masks, edge-compare values and the enable bit, and it reads factor flags, which clear when they are read.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every register reads 0, `int_req_o` and `entry_busy_o` are 0, and `cpu_clk_en_o` is 1.
- R2: A falling edge on `ct_tick_i[k]` sets clock-timer flag k at address 1, where bit 0 is 32 Hz, bit 1 is 8 Hz and bit 2 is 2 Hz. A falling edge on `sw_tick_i[k]` sets stopwatch flag k at address 3, where bit 0 is 10 Hz and bit 1 is 1 Hz. A one-cycle `sio_done_i` pulse sets the serial flag at address 5 bit 0. All of these flags are set whatever the state of their mask bits.
- R3: A read (`reg_rd_i`) of a flag address (1, 3, 5 or 10) returns the current flags in the same cycle and clears them at that clock edge. If a set event for a flag falls in the same cycle as the clearing read, the flag ends up set.
- R4: Key flags live at address 10: bit 0 for group 0, bit 1 for group 1 and bit 2 for group 2.
  - Group 0 (4 pins) and group 1 (1 pin) set their flag when an enabled pin goes from equal to its compare bit to different from it.
  - Group 2 (4 pins) sets its flag on a rising edge of an enabled pin.
  - A pin whose mask bit is 0 never sets a flag.
- R5: `int_req_o` is 1 when three conditions all hold: the global enable is 1, no entry is in progress, and at least one group is pending. A timer, stopwatch or serial group is pending when a flag AND its mask bit is 1. A key group is pending when its flag is 1.
- R6: Vector bit 0 is serial, bit 1 is any key group, bit 2 is clock timer and bit 3 is stopwatch. `int_addr_o` is {VEC_PAGE, vector}, which is 8'h1v with the default page.
- R7: On an edge where both `int_req_o` and `int_ack_i` are high, the vector is captured and the global enable is cleared. This happens even if a software write of 1 to the enable bit falls in the same cycle.
- R8: After acceptance, `entry_busy_o` is high for exactly ENTRY_CYCLES (12) cycles. During that window `int_addr_o` does not change and `int_req_o` stays 0.
- R9: The read/write registers are:

  | Address | Contents |
  |---|---|
  | 0 | clock-timer masks, bits 2:0 |
  | 2 | stopwatch masks, bits 1:0 |
  | 4 | serial mask, bit 0 |
  | 6 | group-0 masks |
  | 7 | group-0 compare bits |
  | 8 | group-1 mask in bit 0, compare in bit 1 |
  | 9 | group-2 masks |
  | 11 | global enable, bit 0 |

  Each reads back what was written. Unused addresses read 0.
- R10: A `halt_i` pulse drops `cpu_clk_en_o` at the next edge. While the CPU is halted, an edge at which the enable is 1 and some group is pending raises `cpu_clk_en_o` again.
- R11: While the CPU is halted, `wdt_rst_i` raises `cpu_clk_en_o` only when `wdt_en_i` is 1. Pending flags with the global enable at 0 do not wake the CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ct_tick_i | input | CT_N | Clock-timer rate signals (levels) |
| sw_tick_i | input | SW_N | Stopwatch rate signals (levels) |
| sio_done_i | input | 1 | Serial transfer complete pulse |
| kg0_pin_i | input | KG0_N | Key group 0 pins |
| kg1_pin_i | input | 1 | Key group 1 pin |
| kg2_pin_i | input | KG2_N | Key group 2 pins |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears flags) |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | 4 | Register read data |
| int_req_o | output | 1 | Interrupt request (valid) |
| int_ack_i | input | 1 | Interrupt acknowledge (ready) |
| int_addr_o | output | 8 | Captured vector address |
| entry_busy_o | output | 1 | Entry window in progress |
| halt_i | input | 1 | CPU enters halt (pulse) |
| wdt_rst_i | input | 1 | Watchdog reset pulse |
| wdt_en_i | input | 1 | Watchdog enabled |
| cpu_clk_en_o | output | 1 | CPU clock enable |

## Verification
The bench drives several groups at the same time and expects a combined vector such as 8'h19. A priority encoder would report only one group there.

It lines up a clearing read with a timer edge in the same cycle. A design that lets the clear win would lose that event.

It acknowledges while also writing 1 to the enable bit. A design that lets the write win would re-raise the request straight after the entry window.

It toggles masked key pins and moves a compare-mode pin in the direction that should not count. This catches flags that are gated only at the request stage or that trigger on the wrong edge.

Halt cases cover three wake-up conditions:
- A watchdog reset while the watchdog is disabled must not wake the CPU.
- Pending flags with the enable at 0 must not wake the CPU.
- Enabling interrupts must wake it.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 4;
  localparam int GRP_N  = 4;

  localparam logic [ADDR_W-1:0] A_CT_MASK  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CT_FLAG  = 4'd1;
  localparam logic [ADDR_W-1:0] A_SW_MASK  = 4'd2;
  localparam logic [ADDR_W-1:0] A_SW_FLAG  = 4'd3;
  localparam logic [ADDR_W-1:0] A_SIO_MASK = 4'd4;
  localparam logic [ADDR_W-1:0] A_SIO_FLAG = 4'd5;
  localparam logic [ADDR_W-1:0] A_KG0_MASK = 4'd6;
  localparam logic [ADDR_W-1:0] A_KG0_CMP  = 4'd7;
  localparam logic [ADDR_W-1:0] A_KG1_CTL  = 4'd8;
  localparam logic [ADDR_W-1:0] A_KG2_MASK = 4'd9;
  localparam logic [ADDR_W-1:0] A_KEY_FLAG = 4'd10;
  localparam logic [ADDR_W-1:0] A_IE       = 4'd11;

  // vector bit order decoded by the CPU jump logic
  typedef struct packed {
    logic stopwatch;
    logic clock_timer;
    logic key;
    logic serial;
  } grp_pend_t;
endpackage

// File: rtl/irqv_flag_bank.sv
module irqv_flag_bank #(
  parameter int N           = 3,
  parameter bit FALL_DETECT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] set_ev;
  logic [N-1:0] flag_q;

  generate
    if (FALL_DETECT) begin : g_fall
      logic [N-1:0] prev_q;
      always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= src_i;
      end
      assign set_ev = prev_q & ~src_i;
    end else begin : g_pulse
      assign set_ev = src_i;
    end
  endgenerate

  // a set event in the clearing cycle survives
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (clr_i ? '0 : flag_q) | set_ev;
  end

  assign flag_o = flag_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      // R3
      set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_ev[i]) |=> flag_q[i]);
      // R2
      flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[i] && !clr_i) |=> flag_q[i]);
    end
  endgenerate
endmodule

// File: rtl/irqv_key_group.sv
module irqv_key_group #(
  parameter int N        = 4,
  parameter bit CMP_MODE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] cmp_i,
  input  logic [N-1:0] mask_i,
  input  logic         clr_i,
  output logic         flag_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] edge_ev;
  logic         set_ev;
  logic         flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_i;
  end

  generate
    if (CMP_MODE) begin : g_cmp
      assign edge_ev = ~(prev_q ^ cmp_i) & (pin_i ^ cmp_i);
    end else begin : g_rise
      logic cmp_unused;
      assign cmp_unused = ^cmp_i;
      assign edge_ev = ~prev_q & pin_i;
    end
  endgenerate

  assign set_ev = |(edge_ev & mask_i);

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= (clr_i ? 1'b0 : flag_q) | set_ev;
  end

  assign flag_o = flag_q;

  // R4
  masked_pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && mask_i == '0) |=> !flag_q);
  // R3
  key_set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag_q);
endmodule

// File: rtl/irqv_seq.sv
module irqv_seq #(
  parameter int ENTRY_CYCLES = 12,
  parameter int VEC_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] pend_i,
  input  logic             ie_wr_i,
  input  logic             ie_wdata_i,
  input  logic             int_ack_i,
  input  logic             halt_i,
  input  logic             wdt_rst_i,
  input  logic             wdt_en_i,
  output logic             ie_o,
  output logic             int_req_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             busy_o,
  output logic             clk_en_o
);
  localparam int CNT_W = $clog2(ENTRY_CYCLES + 1);

  logic             ie_q;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [VEC_W-1:0] vec_q;
  logic             halted_q;
  logic             accept;
  logic             wake;

  assign int_req_o = ie_q & ~busy_q & (|pend_i);
  assign accept    = int_req_o & int_ack_i;
  assign wake      = (ie_q & (|pend_i)) | (wdt_rst_i & wdt_en_i);

  always_ff @(posedge clk) begin
    if (!rst_n)       ie_q <= 1'b0;
    else if (accept)  ie_q <= 1'b0;
    else if (ie_wr_i) ie_q <= ie_wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      vec_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(ENTRY_CYCLES - 1);
      vec_q  <= pend_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                halted_q <= 1'b0;
    else if (halt_i)           halted_q <= 1'b1;
    else if (halted_q && wake) halted_q <= 1'b0;
  end

  assign ie_o     = ie_q;
  assign vec_o    = vec_q;
  assign busy_o   = busy_q;
  assign clk_en_o = ~halted_q;

  // R7
  ack_drops_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req_o && int_ack_i) |=> (!ie_q && busy_q));
  // R6
  captured_vec_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req_o && int_ack_i) |=> (vec_q != '0));
  // R8
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && $stable(vec_q)));
  // R8
  entry_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CNT_W'(ENTRY_CYCLES)));
  // R10
  wake_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_o && ie_q && (|pend_i) && !halt_i) |=> clk_en_o);
  // R11
  no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_o && !ie_q && !(wdt_rst_i && wdt_en_i)) |=> !clk_en_o);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int          CT_N         = 3,
  parameter int          SW_N         = 2,
  parameter int          KG0_N        = 4,
  parameter int          KG2_N        = 4,
  parameter int          ENTRY_CYCLES = 12,
  parameter logic [3:0]  VEC_PAGE     = 4'h1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CT_N-1:0]  ct_tick_i,
  input  logic [SW_N-1:0]  sw_tick_i,
  input  logic             sio_done_i,
  input  logic [KG0_N-1:0] kg0_pin_i,
  input  logic             kg1_pin_i,
  input  logic [KG2_N-1:0] kg2_pin_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [3:0]       reg_addr_i,
  input  logic [3:0]       reg_wdata_i,
  output logic [3:0]       reg_rdata_o,
  output logic             int_req_o,
  input  logic             int_ack_i,
  output logic [7:0]       int_addr_o,
  output logic             entry_busy_o,
  input  logic             halt_i,
  input  logic             wdt_rst_i,
  input  logic             wdt_en_i,
  output logic             cpu_clk_en_o
);
  import irqv_pkg::*;

  logic [CT_N-1:0]  ct_mask_q,  ct_flag;
  logic [SW_N-1:0]  sw_mask_q,  sw_flag;
  logic             sio_mask_q;
  logic [0:0]       sio_flag;
  logic [KG0_N-1:0] kg0_mask_q, kg0_cmp_q;
  logic             kg1_mask_q, kg1_cmp_q;
  logic [KG2_N-1:0] kg2_mask_q;
  logic             kg0_flag, kg1_flag, kg2_flag;
  logic             ie;
  logic [GRP_N-1:0] vec;
  grp_pend_t        pend;

  logic wr_hit, rd_hit;
  assign wr_hit = reg_wr_i;
  assign rd_hit = reg_rd_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ct_mask_q  <= '0;
      sw_mask_q  <= '0;
      sio_mask_q <= 1'b0;
      kg0_mask_q <= '0;
      kg0_cmp_q  <= '0;
      kg1_mask_q <= 1'b0;
      kg1_cmp_q  <= 1'b0;
      kg2_mask_q <= '0;
    end else if (wr_hit) begin
      case (reg_addr_i)
        A_CT_MASK:  ct_mask_q  <= CT_N'(reg_wdata_i);
        A_SW_MASK:  sw_mask_q  <= SW_N'(reg_wdata_i);
        A_SIO_MASK: sio_mask_q <= reg_wdata_i[0];
        A_KG0_MASK: kg0_mask_q <= KG0_N'(reg_wdata_i);
        A_KG0_CMP:  kg0_cmp_q  <= KG0_N'(reg_wdata_i);
        A_KG1_CTL: begin
          kg1_mask_q <= reg_wdata_i[0];
          kg1_cmp_q  <= reg_wdata_i[1];
        end
        A_KG2_MASK: kg2_mask_q <= KG2_N'(reg_wdata_i);
        default: ;
      endcase
    end
  end

  irqv_flag_bank #(.N(CT_N), .FALL_DETECT(1'b1)) u_ct (
    .clk(clk), .rst_n(rst_n), .src_i(ct_tick_i),
    .clr_i(rd_hit && reg_addr_i == A_CT_FLAG), .flag_o(ct_flag));

  irqv_flag_bank #(.N(SW_N), .FALL_DETECT(1'b1)) u_sw (
    .clk(clk), .rst_n(rst_n), .src_i(sw_tick_i),
    .clr_i(rd_hit && reg_addr_i == A_SW_FLAG), .flag_o(sw_flag));

  irqv_flag_bank #(.N(1), .FALL_DETECT(1'b0)) u_sio (
    .clk(clk), .rst_n(rst_n), .src_i(sio_done_i),
    .clr_i(rd_hit && reg_addr_i == A_SIO_FLAG), .flag_o(sio_flag));

  logic key_clr;
  assign key_clr = rd_hit && reg_addr_i == A_KEY_FLAG;

  irqv_key_group #(.N(KG0_N), .CMP_MODE(1'b1)) u_kg0 (
    .clk(clk), .rst_n(rst_n), .pin_i(kg0_pin_i), .cmp_i(kg0_cmp_q),
    .mask_i(kg0_mask_q), .clr_i(key_clr), .flag_o(kg0_flag));

  irqv_key_group #(.N(1), .CMP_MODE(1'b1)) u_kg1 (
    .clk(clk), .rst_n(rst_n), .pin_i(kg1_pin_i), .cmp_i(kg1_cmp_q),
    .mask_i(kg1_mask_q), .clr_i(key_clr), .flag_o(kg1_flag));

  irqv_key_group #(.N(KG2_N), .CMP_MODE(1'b0)) u_kg2 (
    .clk(clk), .rst_n(rst_n), .pin_i(kg2_pin_i), .cmp_i('0),
    .mask_i(kg2_mask_q), .clr_i(key_clr), .flag_o(kg2_flag));

  assign pend.serial      = sio_flag[0] & sio_mask_q;
  assign pend.key         = kg0_flag | kg1_flag | kg2_flag;
  assign pend.clock_timer = |(ct_flag & ct_mask_q);
  assign pend.stopwatch   = |(sw_flag & sw_mask_q);

  irqv_seq #(.ENTRY_CYCLES(ENTRY_CYCLES), .VEC_W(GRP_N)) u_seq (
    .clk(clk), .rst_n(rst_n), .pend_i(pend),
    .ie_wr_i(wr_hit && reg_addr_i == A_IE), .ie_wdata_i(reg_wdata_i[0]),
    .int_ack_i(int_ack_i), .halt_i(halt_i), .wdt_rst_i(wdt_rst_i),
    .wdt_en_i(wdt_en_i), .ie_o(ie), .int_req_o(int_req_o), .vec_o(vec),
    .busy_o(entry_busy_o), .clk_en_o(cpu_clk_en_o));

  assign int_addr_o = {VEC_PAGE, vec};

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CT_MASK:  reg_rdata_o = DATA_W'(ct_mask_q);
      A_CT_FLAG:  reg_rdata_o = DATA_W'(ct_flag);
      A_SW_MASK:  reg_rdata_o = DATA_W'(sw_mask_q);
      A_SW_FLAG:  reg_rdata_o = DATA_W'(sw_flag);
      A_SIO_MASK: reg_rdata_o = DATA_W'(sio_mask_q);
      A_SIO_FLAG: reg_rdata_o = DATA_W'(sio_flag);
      A_KG0_MASK: reg_rdata_o = DATA_W'(kg0_mask_q);
      A_KG0_CMP:  reg_rdata_o = DATA_W'(kg0_cmp_q);
      A_KG1_CTL:  reg_rdata_o = DATA_W'({kg1_cmp_q, kg1_mask_q});
      A_KG2_MASK: reg_rdata_o = DATA_W'(kg2_mask_q);
      A_KEY_FLAG: reg_rdata_o = DATA_W'({kg2_flag, kg1_flag, kg0_flag});
      A_IE:       reg_rdata_o = DATA_W'(ie);
      default:    reg_rdata_o = '0;
    endcase
  end

  // R5
  req_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_req_o |-> (|{pend.stopwatch, pend.clock_timer, pend.key, pend.serial}));
  // R8
  quiet_during_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_busy_o |-> !int_req_o);
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;
  localparam logic [3:0] CT_MASK = 4'd0, CT_FLAG = 4'd1, SW_MASK = 4'd2,
    SW_FLAG = 4'd3, SIO_MASK = 4'd4, SIO_FLAG = 4'd5, KG0_MASK = 4'd6,
    KG0_CMP = 4'd7, KG1_CTL = 4'd8, KG2_MASK = 4'd9, KEY_FLAG = 4'd10,
    IE_REG = 4'd11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] ct_tick = '0;
  logic [1:0] sw_tick = '0;
  logic sio_done = 1'b0;
  logic [3:0] kg0_pin = '0;
  logic kg1_pin = 1'b0;
  logic [3:0] kg2_pin = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0, reg_wdata = '0;
  logic [3:0] reg_rdata;
  logic int_req, int_ack = 1'b0;
  logic [7:0] int_addr;
  logic entry_busy;
  logic halt = 1'b0, wdt_rst = 1'b0, wdt_en = 1'b0;
  logic cpu_clk_en;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  logic busy_d = 1'b0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ct_tick_i(ct_tick), .sw_tick_i(sw_tick),
    .sio_done_i(sio_done), .kg0_pin_i(kg0_pin), .kg1_pin_i(kg1_pin),
    .kg2_pin_i(kg2_pin), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .int_req_o(int_req), .int_ack_i(int_ack), .int_addr_o(int_addr),
    .entry_busy_o(entry_busy), .halt_i(halt), .wdt_rst_i(wdt_rst),
    .wdt_en_i(wdt_en), .cpu_clk_en_o(cpu_clk_en));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected address per accepted interrupt (R6)
  always @(negedge clk) begin
    if (entry_busy && !busy_d) begin
      if (exp_q.size() == 0) chk("R6 unexpected entry", {24'd0, int_addr}, 32'hFFFF);
      else chk("R6 vector address", {24'd0, int_addr}, {24'd0, exp_q.pop_front()});
    end
    busy_d = entry_busy;
  end

  task automatic expect_vec(input logic [7:0] a);
    exp_q.push_back(a);
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [3:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic ct_fall(input int i);
    @(negedge clk); ct_tick[i] = 1'b1;
    @(negedge clk); ct_tick[i] = 1'b0;
    @(negedge clk);
  endtask

  task automatic sw_fall(input int i);
    @(negedge clk); sw_tick[i] = 1'b1;
    @(negedge clk); sw_tick[i] = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_ack(input bit with_ie, output int nbusy, output bit steady);
    logic [7:0] a0;
    int t;
    t = 0;
    while (!int_req && t < 50) begin @(negedge clk); t++; end
    int_ack = 1'b1;
    if (with_ie) begin reg_wr = 1'b1; reg_addr = IE_REG; reg_wdata = 4'd1; end
    @(negedge clk); int_ack = 1'b0; reg_wr = 1'b0;
    nbusy = 0; steady = 1'b1; a0 = int_addr;
    while (entry_busy && nbusy < 40) begin
      nbusy++;
      if (int_req || int_addr !== a0) steady = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] d;
    int nb;
    bit st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 int_req", int_req, 0);
    chk("R1 entry_busy", entry_busy, 0);
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    for (int a = 0; a < 12; a++) begin
      rd(a[3:0], d);
      chk("R1 register zero", d, 0);
    end

    // R2 flag set with mask 0; R5 no request without mask
    wr(IE_REG, 4'd1);
    ct_fall(0);
    chk("R5 masked flag no request", int_req, 0);
    rd(CT_FLAG, d); chk("R2 clock 32Hz flag", d, 4'b0001);
    rd(CT_FLAG, d); chk("R3 cleared by read", d, 0);
    wr(IE_REG, 4'd0);

    // R9 readback
    wr(CT_MASK, 4'b0100);
    rd(CT_MASK, d); chk("R9 ct mask readback", d, 4'b0100);
    rd(IE_REG, d); chk("R9 ie readback", d, 0);
    rd(4'd13, d); chk("R9 unused address", d, 0);

    // R5 enable gating, R7, R8
    ct_fall(2);
    chk("R5 no request when disabled", int_req, 0);
    wr(IE_REG, 4'd1);
    chk("R5 request when enabled", int_req, 1);
    expect_vec(8'h14);
    do_ack(1'b0, nb, st);
    chk("R8 entry length", nb, 12);
    chk("R8 address stable, no request", st, 1);
    rd(IE_REG, d); chk("R7 ie cleared on accept", d, 0);
    chk("R7 no request after entry", int_req, 0);
    rd(CT_FLAG, d); chk("R2 clock 2Hz flag", d, 4'b0100);

    // R6 combined vector, R7 ack beats ie write
    wr(SIO_MASK, 4'd1);
    wr(SW_MASK, 4'b0010);
    @(negedge clk); sio_done = 1'b1;
    @(negedge clk); sio_done = 1'b0;
    sw_fall(1);
    rd(SW_MASK, d); chk("R9 sw mask readback", d, 4'b0010);
    wr(IE_REG, 4'd1);
    expect_vec(8'h19);
    do_ack(1'b1, nb, st);
    chk("R8 entry length combined", nb, 12);
    rd(IE_REG, d); chk("R7 ack wins over ie write", d, 0);
    rd(SW_FLAG, d); chk("R2 stopwatch 1Hz flag", d, 4'b0010);
    rd(SIO_FLAG, d); chk("R2 serial flag", d, 4'b0001);

    // R4 key groups
    wr(KG0_MASK, 4'b0100);
    wr(KG0_CMP, 4'b0000);
    @(negedge clk); kg0_pin[1] = 1'b1;
    repeat (2) @(negedge clk);
    rd(KEY_FLAG, d); chk("R4 masked pin ignored", d, 0);
    wr(KG1_CTL, 4'b0011);
    rd(KG1_CTL, d); chk("R9 group1 control readback", d, 4'b0011);
    @(negedge clk); kg1_pin = 1'b1;
    repeat (2) @(negedge clk);
    rd(KEY_FLAG, d); chk("R4 group1 wrong direction", d, 0);
    @(negedge clk); kg1_pin = 1'b0;
    wr(KG2_MASK, 4'b0001);
    @(negedge clk); kg2_pin[0] = 1'b1;
    @(negedge clk); kg0_pin[2] = 1'b1;
    repeat (2) @(negedge clk);
    wr(IE_REG, 4'd1);
    expect_vec(8'h12);
    do_ack(1'b0, nb, st);
    rd(KEY_FLAG, d); chk("R4 all key groups set", d, 4'b0111);
    rd(KEY_FLAG, d); chk("R3 key flags cleared", d, 0);

    // R3 set in the clearing cycle wins
    @(negedge clk); ct_tick[1] = 1'b1;
    @(negedge clk); ct_tick[1] = 1'b0; reg_rd = 1'b1; reg_addr = CT_FLAG;
    @(negedge clk); reg_rd = 1'b0;
    rd(CT_FLAG, d); chk("R3 set beats clear", d, 4'b0010);

    // R10 / R11 halt
    wr(CT_MASK, 4'b0001);
    @(negedge clk); halt = 1'b1;
    @(negedge clk); halt = 1'b0;
    chk("R10 halt stops clock", cpu_clk_en, 0);
    ct_fall(0);
    chk("R11 pending with ie=0 no wake", cpu_clk_en, 0);
    @(negedge clk); wdt_rst = 1'b1;
    @(negedge clk); wdt_rst = 1'b0;
    chk("R11 watchdog disabled no wake", cpu_clk_en, 0);
    wdt_en = 1'b1;
    @(negedge clk); wdt_rst = 1'b1;
    @(negedge clk); wdt_rst = 1'b0;
    chk("R11 watchdog wake", cpu_clk_en, 1);
    @(negedge clk); halt = 1'b1;
    @(negedge clk); halt = 1'b0;
    chk("R10 halt again", cpu_clk_en, 0);
    wr(IE_REG, 4'd1);
    @(negedge clk);
    chk("R10 interrupt wake", cpu_clk_en, 1);
    expect_vec(8'h14);
    do_ack(1'b0, nb, st);
    rd(CT_FLAG, d); chk("R2 flag kept through halt", d, 4'b0001);

    repeat (3) @(negedge clk);
    chk("R6 all expected entries seen", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule